// File: doc/BRIEF.md
# PS/2 Mouse Packet Transmitter

This block sends one mouse report as a four-byte packet on the two open-drain PS/2 lines, clock and data. The device side generates the clock, so the block produces both lines. A single-cycle send strobe latches the two button states, the two movement sign bits and the signed 8-bit X and Y movement values. The block then shifts them out as four serial frames. The first three bytes come from a 24-bit payload register that is loaded in one step. The fourth byte is always zero, because the mouse has no wheel.

Each frame has eleven bits: a low start bit, eight data bits sent least significant bit first, an odd parity bit and a high stop bit. The PS/2 clock comes from a divider of the system clock. One half bit period is `HALF_BIT_CLKS` system clocks, and the default of 2000 gives about 12.5 kHz at 50 MHz. The block changes the data line only while the clock is released, so the host samples stable data on each falling clock edge. Both lines are modelled as drive-low enables: a released line reads as 1.

Top module: `ps2_mouse_tx`

## Requirements
- R1: After reset, and whenever no packet is in progress, `busy_o`, `ps2_clk_low_o` and `ps2_dat_low_o` are all 0, so both lines are released.
- R2: Every frame begins with a start bit of 0 (data driven low) and ends with a stop bit of 1 (data released).
- R3: A packet holds four frames in this order: status byte, X byte, Y byte, zero byte. Within each frame, data bit 0 is sent first and bit 7 last.
- R4: The status byte holds, from bit 0 up to bit 7: left button, right button, constant 0, constant 1, X sign, Y sign, constant 0, constant 0.
- R5: The second byte equals `x_move_i` and the third byte equals `y_move_i`, as captured at the strobe.
- R6: The fourth byte is always 0x00.
- R7: The ninth bit after the start bit is odd parity, so the eight data bits and the parity bit together contain an odd number of ones.
- R8: Within a frame, each bit holds the clock released for `HALF_BIT_CLKS` cycles and then drives it low for `HALF_BIT_CLKS` cycles.
- R9: The data line changes only in a cycle where the clock is released, and it holds its value through each falling edge of the clock.
- R10: Between two frames of the same packet, the clock stays released for a gap of one bit time, `2*HALF_BIT_CLKS` cycles, before the next frame's first released half. The clock therefore stays high for `3*HALF_BIT_CLKS` cycles.
- R11: `busy_o` rises in the cycle after an accepted strobe. It falls on the same edge that releases the clock at the end of the fourth frame's stop bit.
- R12: A strobe that arrives while `busy_o` is high is ignored, and the packet in progress is sent unchanged.
- R13: Input values are captured only when a strobe is accepted. Later changes on the inputs during the packet have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Send strobe; starts a packet when idle |
| btn_left_i | input | 1 | Left button state |
| btn_right_i | input | 1 | Right button state |
| x_sign_i | input | 1 | X movement sign bit |
| y_sign_i | input | 1 | Y movement sign bit |
| x_move_i | input | 8 | X movement value |
| y_move_i | input | 8 | Y movement value |
| busy_o | output | 1 | High while a packet is being sent |
| ps2_clk_low_o | output | 1 | Drive-low enable for the PS/2 clock line |
| ps2_dat_low_o | output | 1 | Drive-low enable for the PS/2 data line |

## Verification
The bench decodes the lines as a host would. It samples data on each falling clock edge, so a wrong bit or byte index, or a payload shift that comes too early or too late, shows as a wrong bit within that same bit period. A divider or half-phase fault changes the measured high or low width at the very next clock edge, and a gap fault shows at the first bit of the following frame. A stuck state fault shows as a missing release or as `busy_o` still high when the fourth frame's clock release arrives.

// File: rtl/ps2_mouse_tx.sv
module ps2_mouse_tx #(
  parameter int HALF_BIT_CLKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_i,
  input  logic       btn_left_i,
  input  logic       btn_right_i,
  input  logic       x_sign_i,
  input  logic       y_sign_i,
  input  logic [7:0] x_move_i,
  input  logic [7:0] y_move_i,
  output logic       busy_o,
  output logic       ps2_clk_low_o,
  output logic       ps2_dat_low_o
);

  localparam int DW = (HALF_BIT_CLKS > 1) ? $clog2(HALF_BIT_CLKS) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_BIT_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP} state_t;

  state_t      state;
  logic [DW-1:0] div;
  logic        low_half;
  logic [3:0]  bit_idx;
  logic [1:0]  byte_idx;
  logic [23:0] payload;
  logic        par;

  logic tick, data_slot, line_bit, payload_bit;

  assign tick        = (div == DIV_LAST);
  assign data_slot   = (bit_idx >= 4'd1) && (bit_idx <= 4'd8);
  assign payload_bit = (byte_idx != 2'd3) ? payload[0] : 1'b0;

  always_comb begin
    if (bit_idx == 4'd0)       line_bit = 1'b0;
    else if (data_slot)        line_bit = payload_bit;
    else if (bit_idx == 4'd9)  line_bit = par;
    else                       line_bit = 1'b1;
  end

  assign busy_o        = (state != S_IDLE);
  assign ps2_clk_low_o = (state == S_FRAME) && low_half;
  assign ps2_dat_low_o = (state == S_FRAME) && !line_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div      <= '0;
      low_half <= 1'b0;
      bit_idx  <= '0;
      byte_idx <= '0;
      payload  <= '0;
      par      <= 1'b1;
    end else begin
      case (state)
        S_IDLE: begin
          if (send_i) begin
            state    <= S_FRAME;
            div      <= '0;
            low_half <= 1'b0;
            bit_idx  <= '0;
            byte_idx <= '0;
            par      <= 1'b1;
            payload  <= {y_move_i, x_move_i,
                         2'b00, y_sign_i, x_sign_i, 1'b1, 1'b0, btn_right_i, btn_left_i};
          end
        end
        S_FRAME: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!low_half) begin
              low_half <= 1'b1;
            end else begin
              low_half <= 1'b0;
              if (data_slot) begin
                par <= par ^ line_bit;
                if (byte_idx != 2'd3) payload <= payload >> 1;
              end
              if (bit_idx == 4'd10) begin
                bit_idx <= '0;
                par     <= 1'b1;
                state   <= (byte_idx == 2'd3) ? S_IDLE : S_GAP;
              end else begin
                bit_idx <= bit_idx + 4'd1;
              end
            end
          end
        end
        S_GAP: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!low_half) begin
              low_half <= 1'b1;
            end else begin
              low_half <= 1'b0;
              byte_idx <= byte_idx + 2'd1;
              state    <= S_FRAME;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ps2_mouse_tx_chk.sv
module ps2_mouse_tx_chk #(
  parameter int HALF_BIT_CLKS = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic send_i,
  input logic busy_o,
  input logic ps2_clk_low_o,
  input logic ps2_dat_low_o
);

  int low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_cnt <= 0;
    else if (ps2_clk_low_o) low_cnt <= low_cnt + 1;
    else                    low_cnt <= 0;
  end

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ps2_clk_low_o && !ps2_dat_low_o));

  a_r9_data_moves_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ps2_dat_low_o) |-> !ps2_clk_low_o);

  a_r9_data_stable_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_clk_low_o) |-> $stable(ps2_dat_low_o));

  a_r8_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_low_o) |-> (low_cnt == HALF_BIT_CLKS));

  a_r11_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (send_i && !busy_o) |=> busy_o);

  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (send_i && busy_o && !ps2_clk_low_o) |=> busy_o);

  a_r11_busy_ends_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $fell(ps2_clk_low_o));

endmodule

bind ps2_mouse_tx ps2_mouse_tx_chk #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .send_i(send_i),
  .busy_o(busy_o),
  .ps2_clk_low_o(ps2_clk_low_o),
  .ps2_dat_low_o(ps2_dat_low_o)
);

// File: tb/ps2_mouse_tx_tb.sv
`timescale 1ns/1ps
module ps2_mouse_tx_tb_top;

  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_i = 1'b0;
  logic btn_left_i = 1'b0, btn_right_i = 1'b0, x_sign_i = 1'b0, y_sign_i = 1'b0;
  logic [7:0] x_move_i = '0, y_move_i = '0;
  logic busy_o, ps2_clk_low_o, ps2_dat_low_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ps2_mouse_tx #(.HALF_BIT_CLKS(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_i(send_i),
    .btn_left_i(btn_left_i), .btn_right_i(btn_right_i),
    .x_sign_i(x_sign_i), .y_sign_i(y_sign_i),
    .x_move_i(x_move_i), .y_move_i(y_move_i),
    .busy_o(busy_o), .ps2_clk_low_o(ps2_clk_low_o), .ps2_dat_low_o(ps2_dat_low_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_packet(input logic l, input logic r, input logic xs, input logic ys,
                            input logic [7:0] x, input logic [7:0] y, input bit poke);
    logic [7:0] bytes [4];
    int hc, lc;
    logic exp_bit;
    bytes[0] = {2'b00, ys, xs, 1'b1, 1'b0, r, l};
    bytes[1] = x;
    bytes[2] = y;
    bytes[3] = 8'h00;
    btn_left_i = l; btn_right_i = r; x_sign_i = xs; y_sign_i = ys;
    x_move_i = x; y_move_i = y;
    send_i = 1'b1;
    @(negedge clk);
    send_i = 1'b0;
    // R13: scramble inputs after capture
    btn_left_i = ~l; btn_right_i = ~r; x_sign_i = ~xs; y_sign_i = ~ys;
    x_move_i = ~x; y_move_i = y ^ 8'h5a;
    chk(busy_o == 1'b1, "R11 busy after strobe", int'(busy_o), 1);
    chk(ps2_clk_low_o == 1'b0, "R8 clock released first half", int'(ps2_clk_low_o), 0);
    hc = 1;
    for (int f = 0; f < 4; f++) begin
      for (int b = 0; b < 11; b++) begin
        forever begin
          @(negedge clk);
          if (ps2_clk_low_o) break;
          hc++;
          if (poke && f == 1 && b == 3 && hc == 2) begin
            send_i = 1'b1;
            x_move_i = 8'h3c; y_move_i = 8'hc3; btn_left_i = 1'b1;
          end
          if (poke && f == 1 && b == 3 && hc == 3) send_i = 1'b0;
        end
        if (b == 0 && f != 0)
          chk(hc == 3 * HALF, "R10 inter-frame gap", hc, 3 * HALF);
        else
          chk(hc == HALF, "R8 released half width", hc, HALF);
        if (b == 0)       exp_bit = 1'b0;
        else if (b <= 8)  exp_bit = bytes[f][b-1];
        else if (b == 9)  exp_bit = ~(^bytes[f]);
        else              exp_bit = 1'b1;
        if (b == 0 || b == 10)
          chk(~ps2_dat_low_o == exp_bit, "R2 start/stop bit", int'(~ps2_dat_low_o), int'(exp_bit));
        else if (b == 9)
          chk(~ps2_dat_low_o == exp_bit, "R7 odd parity", int'(~ps2_dat_low_o), int'(exp_bit));
        else if (f == 0)
          chk(~ps2_dat_low_o == exp_bit, poke ? "R12 R4 status bit" : "R4 R3 status bit",
              int'(~ps2_dat_low_o), int'(exp_bit));
        else if (f == 3)
          chk(~ps2_dat_low_o == exp_bit, "R6 zero byte", int'(~ps2_dat_low_o), int'(exp_bit));
        else
          chk(~ps2_dat_low_o == exp_bit, poke ? "R12 R13 R5 movement bit" : "R5 R13 movement bit",
              int'(~ps2_dat_low_o), int'(exp_bit));
        chk(busy_o == 1'b1, "R11 busy during packet", int'(busy_o), 1);
        lc = 1;
        forever begin
          @(negedge clk);
          if (!ps2_clk_low_o) break;
          lc++;
        end
        chk(lc == HALF, "R8 low half width", lc, HALF);
        hc = 1;
      end
    end
    chk(busy_o == 1'b0, "R11 busy ends with last release", int'(busy_o), 0);
    chk(ps2_dat_low_o == 1'b0, "R1 data released after packet", int'(ps2_dat_low_o), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!busy_o && !ps2_clk_low_o && !ps2_dat_low_o, "R1 idle released",
          {busy_o, ps2_clk_low_o, ps2_dat_low_o}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy_o, ps2_clk_low_o, ps2_dat_low_o} == 3'b000, "R1 reset state",
        {busy_o, ps2_clk_low_o, ps2_dat_low_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, ps2_clk_low_o, ps2_dat_low_o} == 3'b000, "R1 idle after reset",
        {busy_o, ps2_clk_low_o, ps2_dat_low_o}, 0);
    for (int i = 0; i < 16; i++)
      run_packet(i[0], i[1], i[2], i[3], 8'(i * 37 + 5), 8'(255 - i * 11), (i == 5) || (i == 12));
    run_packet(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    run_packet(1'b1, 1'b1, 1'b1, 1'b1, 8'hff, 8'hff, 1'b1);
    run_packet(1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 8'h01, 1'b0);
    finish_run();
  end

endmodule